// File: doc/BRIEF.md
# SPI Master with Programmed Chip-Select Timing

This block is an SPI bus master that carries out one complete transfer each time it is started. A transfer applies a chosen pattern to a group of chip-select lines and waits a programmed lead time. It then shifts a fixed number of bytes out on MOSI while shifting the same number in from MISO, MSB first. Between bytes it waits a programmed gap, and after the last byte it waits a programmed tail before it restores the idle chip-select pattern. The SCK half period, clock polarity and sampling phase are run-time settings, so one instance can serve slaves that need different bus settings.

Transmit bytes come from the host through a one-byte port. The block pulses `tx_ready` when it has taken `tx_data`, and the host then presents the next byte. Each received byte appears on `rx_data` with a one-cycle `rx_valid` strobe. Every setting is captured when the transfer starts and has no effect until it ends. When `cfg_release` is set, all bus drivers report high impedance through their enables while the block is idle, so another master can share the bus.

Control is one state machine with six states:
- **IDLE**: waits for `start`; **IDLE→LEAD** on `start`.
- **LEAD**: the active pattern is on the chip selects; **LEAD→BIT** when the lead timer expires and there is at least one byte; **LEAD→TAIL** when the count is zero.
- **BIT**: toggles SCK every half period; **BIT→GAP** after the 16th transition of a byte that is not the last; **BIT→TAIL** after the 16th transition of the last byte.
- **GAP**: **GAP→BIT** when the gap timer expires, loading the next byte.
- **TAIL**: **TAIL→FIN** when the tail timer expires.
- **FIN**: restores the idle pattern and raises `done`; **FIN→IDLE** always.

Top module: `spi_cs_master`

## Requirements
- R1: While reset is held, `cs_o` is all ones and `sck_o`, `mosi_o`, `busy`, `done`, `rx_valid` and `tx_ready` are 0.
- R2: While idle, `cs_o` follows `cfg_cs_idle` and `sck_o` follows `cfg_cpol`, each one clock later.
- R3: From the clock edge that accepts `start` until `done`, `cs_o` holds the `cfg_cs_active` value captured at start.
- R4: The first SCK transition comes L·U + DIV + 2 clocks after `cs_o` takes the active pattern, where L is `cfg_lead_dly`, U is `UNIT_CLKS` and DIV is `cfg_div`.
- R5: Within a byte, SCK transitions are DIV + 1 clocks apart, and every byte has 16 transitions, so a transfer of N bytes has 16·N transitions.
- R6: From the last SCK transition of one byte to the first of the next there are G·U + DIV + 2 clocks, where G is `cfg_gap_dly`.
- R7: `cs_o` returns to the captured idle pattern T·U + 2 clocks after the last SCK transition, where T is `cfg_tail_dly`. `done` is high for exactly that one cycle. With a byte count of 0 there is no SCK transition and the return comes (L + T)·U + 3 clocks after the active pattern.
- R8: Data moves MSB first and full duplex. With `cfg_cpha`=0, MISO is sampled on the leading (away from CPOL) edges and MOSI changes on the trailing edges, with the first bit present before the first edge. With `cfg_cpha`=1, MOSI changes on the leading edges and MISO is sampled on the trailing edges.
- R9: Each received byte is presented on `rx_data` with a `rx_valid` pulse one cycle wide, once per byte, N pulses per transfer.
- R10: `tx_data` is captured on the clock edge that raises `tx_ready`, which is high for one cycle per byte, N pulses per transfer.
- R11: Changes to any `cfg_*` input after start have no effect on the running transfer.
- R12: `sck_oe`, `mosi_oe` and `cs_oe` are 1 while busy. While idle they equal the inverse of `cfg_release`.
- R13: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a transfer when idle |
| cfg_div | input | DIV_W | SCK half period minus one, in clocks |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Sampling phase: 0 samples on leading edges, 1 on trailing edges |
| cfg_nbytes | input | CNT_W | Bytes per transfer |
| cfg_lead_dly | input | DLY_W | Units from chip-select active to data |
| cfg_gap_dly | input | DLY_W | Units between bytes |
| cfg_tail_dly | input | DLY_W | Units from last data to chip-select idle |
| cfg_cs_idle | input | NCS | Chip-select pattern when not transferring |
| cfg_cs_active | input | NCS | Chip-select pattern during a transfer |
| cfg_release | input | 1 | Release bus drivers while idle |
| tx_data | input | DATA_W | Next byte to send |
| tx_ready | output | 1 | Pulse: `tx_data` taken |
| rx_data | output | DATA_W | Last byte received |
| rx_valid | output | 1 | Pulse: `rx_data` new |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulse: transfer complete |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCS | Chip-select lines |
| cs_oe | output | 1 | Chip-select driver enable |

## Verification
Every timing result is counted from a bus event and not from `start`. The first SCK transition is due L·U+DIV+2 clocks after the chip selects change. Later transitions are due DIV+1 clocks apart, or G·U+DIV+2 at a byte boundary. The idle pattern and `done` are due T·U+2 clocks after the final transition. The bench samples every output on the falling clock edge, numbers each falling edge from the one just after the start edge, and compares the difference between edge numbers with these formulas. Because every count is a difference between two edges, the fixed register delay cancels out. `rx_valid` and `tx_ready` are counted and compared at the falling edge after the rising edge that sets them. A slave model in the bench acts on SCK transitions in the same time step and checks the bit order in both directions.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BIT,
        ST_GAP,
        ST_TAIL,
        ST_FIN
    } xfer_state_t;

endpackage

// File: rtl/spi_cs_timer.sv
module spi_cs_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha,
    input  logic              byte_load,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              miso,
    output logic              last_edge,
    output logic              mosi,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int EDGES = 2 * DATA_W;
    localparam int ECW   = $clog2(EDGES);

    logic [ECW-1:0]    ecnt;
    logic [DATA_W-1:0] sreg;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_nxt;
    logic              sample;
    logic              drive;

    assign last_edge = (ecnt == ECW'(EDGES - 1));
    // even edge index = leading edge
    assign sample    = tick && (ecnt[0] == cpha);
    assign drive     = tick && (ecnt[0] != cpha) && !(!cpha && last_edge);
    assign rx_nxt    = sample ? {rx_sh[DATA_W-2:0], miso} : rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt     <= '0;
            sreg     <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            mosi     <= 1'b0;
            tx_ready <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            tx_ready <= byte_load;
            rx_valid <= tick && last_edge;
            if (byte_load) begin
                ecnt  <= '0;
                rx_sh <= '0;
                if (!cpha) begin
                    mosi <= tx_byte[DATA_W-1];
                    sreg <= {tx_byte[DATA_W-2:0], 1'b0};
                end else begin
                    sreg <= tx_byte;
                end
            end else if (tick) begin
                ecnt  <= ecnt + ECW'(1);
                rx_sh <= rx_nxt;
                if (drive) begin
                    mosi <= sreg[DATA_W-1];
                    sreg <= {sreg[DATA_W-2:0], 1'b0};
                end
                if (last_edge) begin
                    rx_data <= rx_nxt;
                end
            end
        end
    end

    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                             // R9
    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_load && tick));                                               // R10
    AST_TXR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);                                             // R10

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int NCS       = 4,
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int CNT_W     = 8,
    parameter int DLY_W     = 8,
    parameter int UNIT_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [CNT_W-1:0]  cfg_nbytes,
    input  logic [DLY_W-1:0]  cfg_lead_dly,
    input  logic [DLY_W-1:0]  cfg_gap_dly,
    input  logic [DLY_W-1:0]  cfg_tail_dly,
    input  logic [NCS-1:0]    cfg_cs_idle,
    input  logic [NCS-1:0]    cfg_cs_active,
    input  logic              cfg_release,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              done,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic [NCS-1:0]    cs_o,
    output logic              cs_oe
);

    localparam int UW    = $clog2(UNIT_CLKS) + 1;
    localparam int SCL_W = DLY_W + UW;
    localparam int TW    = (SCL_W > DIV_W) ? SCL_W : DIV_W;

    xfer_state_t state, state_nx;

    logic [DIV_W-1:0] c_div;
    logic             c_cpha;
    logic [CNT_W-1:0] c_nbytes;
    logic [DLY_W-1:0] c_gap;
    logic [DLY_W-1:0] c_tail;
    logic [NCS-1:0]   c_idle;
    logic [NCS-1:0]   cs_q;
    logic             sck_q;
    logic             done_q;
    logic [CNT_W-1:0] bcnt;

    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_zero;
    logic             byte_load;
    logic             sck_tick;
    logic             last_edge;
    logic             last_byte;

    function automatic logic [TW-1:0] to_clks(input logic [DLY_W-1:0] units);
        return TW'(units) * TW'(UNIT_CLKS);
    endfunction

    assign last_byte = (bcnt == c_nbytes - CNT_W'(1));

    spi_cs_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    spi_cs_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpha      (c_cpha),
        .byte_load (byte_load),
        .tick      (sck_tick),
        .tx_byte   (tx_data),
        .miso      (miso_i),
        .last_edge (last_edge),
        .mosi      (mosi_o),
        .tx_ready  (tx_ready),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    // next-state and timer control
    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        byte_load = 1'b0;
        sck_tick  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = to_clks(cfg_lead_dly);
                end
            end
            ST_LEAD: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (c_nbytes == '0) begin
                        state_nx = ST_TAIL;
                        tmr_val  = to_clks(c_tail);
                    end else begin
                        state_nx  = ST_BIT;
                        tmr_val   = TW'(c_div);
                        byte_load = 1'b1;
                    end
                end
            end
            ST_BIT: begin
                if (tmr_zero) begin
                    sck_tick = 1'b1;
                    tmr_load = 1'b1;
                    if (!last_edge) begin
                        tmr_val = TW'(c_div);
                    end else if (last_byte) begin
                        state_nx = ST_TAIL;
                        tmr_val  = to_clks(c_tail);
                    end else begin
                        state_nx = ST_GAP;
                        tmr_val  = to_clks(c_gap);
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    state_nx  = ST_BIT;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(c_div);
                    byte_load = 1'b1;
                end
            end
            ST_TAIL: begin
                if (tmr_zero) begin
                    state_nx = ST_FIN;
                end
            end
            ST_FIN: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_div    <= '0;
            c_cpha   <= 1'b0;
            c_nbytes <= '0;
            c_gap    <= '0;
            c_tail   <= '0;
            c_idle   <= '1;
            cs_q     <= '1;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
            bcnt     <= '0;
        end else begin
            done_q <= (state == ST_FIN);
            if (state == ST_IDLE) begin
                sck_q <= cfg_cpol;
                if (start) begin
                    c_div    <= cfg_div;
                    c_cpha   <= cfg_cpha;
                    c_nbytes <= cfg_nbytes;
                    c_gap    <= cfg_gap_dly;
                    c_tail   <= cfg_tail_dly;
                    c_idle   <= cfg_cs_idle;
                    cs_q     <= cfg_cs_active;
                    bcnt     <= '0;
                end else begin
                    cs_q <= cfg_cs_idle;
                end
            end else begin
                if (sck_tick) begin
                    sck_q <= ~sck_q;
                end
                if (sck_tick && last_edge) begin
                    bcnt <= bcnt + CNT_W'(1);
                end
                if (state == ST_FIN) begin
                    cs_q <= c_idle;
                end
            end
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign sck_o   = sck_q;
    assign cs_o    = cs_q;
    assign sck_oe  = !(cfg_release && !busy);
    assign mosi_oe = sck_oe;
    assign cs_oe   = sck_oe;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R7
    AST_CS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_o));                            // R3
    AST_DRIVERS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sck_oe && mosi_oe && cs_oe));                        // R12
    AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy && $past(!busy) && $stable(cfg_cpol))
            |-> (sck_o == cfg_cpol));                                        // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                     // R13

endmodule

// File: tb/spi_cs_master_bench.sv
`timescale 1ns/1ps
module spi_cs_master_bench;

    localparam int NCS  = 4;
    localparam int DW   = 8;
    localparam int UNIT = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [7:0]     cfg_div = '0;
    logic           cfg_cpol = 1'b0;
    logic           cfg_cpha = 1'b0;
    logic [7:0]     cfg_nbytes = '0;
    logic [7:0]     cfg_lead_dly = '0;
    logic [7:0]     cfg_gap_dly = '0;
    logic [7:0]     cfg_tail_dly = '0;
    logic [NCS-1:0] cfg_cs_idle = '1;
    logic [NCS-1:0] cfg_cs_active = '0;
    logic           cfg_release = 1'b0;
    logic [DW-1:0]  tx_data;
    logic           tx_ready, rx_valid, busy, done;
    logic [DW-1:0]  rx_data;
    logic           sck_o, sck_oe, mosi_o, mosi_oe, cs_oe;
    logic           miso_i = 1'b0;
    logic [NCS-1:0] cs_o;

    always #2.5 clk = ~clk;

    spi_cs_master #(
        .NCS(NCS), .DATA_W(DW), .DIV_W(8), .CNT_W(8), .DLY_W(8), .UNIT_CLKS(UNIT)
    ) u_spi_cs_master (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_nbytes(cfg_nbytes), .cfg_lead_dly(cfg_lead_dly),
        .cfg_gap_dly(cfg_gap_dly), .cfg_tail_dly(cfg_tail_dly),
        .cfg_cs_idle(cfg_cs_idle), .cfg_cs_active(cfg_cs_active),
        .cfg_release(cfg_release), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
        .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .cs_o(cs_o), .cs_oe(cs_oe)
    );

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic [7:0]  div;
        logic [7:0]  n;
        logic [7:0]  lead;
        logic [7:0]  gap;
        logic [7:0]  tail;
        logic [3:0]  idle;
        logic [3:0]  act;
        logic [31:0] tx;
        logic [31:0] sl;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'd1, 8'd2, 8'd1, 8'd0, 8'd1, 4'hF, 4'hE, 32'hA53C0000, 32'h5AC30000},
        '{1'b0, 1'b1, 8'd0, 8'd3, 8'd0, 8'd1, 8'd0, 4'hF, 4'hD, 32'h817EFF00, 32'h1800E700},
        '{1'b1, 1'b0, 8'd2, 8'd1, 8'd2, 8'd0, 8'd0, 4'hF, 4'hB, 32'h00000000, 32'hFF000000},
        '{1'b1, 1'b1, 8'd1, 8'd4, 8'd0, 8'd2, 8'd3, 4'h0, 4'h5, 32'h12345678, 32'h9ABCDEF0},
        '{1'b0, 1'b0, 8'd0, 8'd1, 8'd0, 8'd0, 8'd0, 4'h3, 4'hC, 32'h80000000, 32'h01000000},
        '{1'b1, 1'b1, 8'd3, 8'd2, 8'd1, 8'd1, 8'd2, 4'hA, 4'h5, 32'h6DB20000, 32'h4ED10000}
    };

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bsel(input logic [31:0] w, input int k);
        return w[31-8*k -: 8];
    endfunction

    // host side of the transmit port
    logic [31:0] cur_tx = '0;
    int          tx_idx = 0;
    always_comb tx_data = (tx_idx < 4) ? bsel(cur_tx, tx_idx) : 8'h00;

    // slave model, acts on every SCK transition
    logic       sl_on = 1'b0;
    logic       sl_cpol = 1'b0;
    logic       sl_cpha = 1'b0;
    logic [7:0] sl_out [4];
    logic [7:0] sl_in  [4];
    logic [7:0] cap = '0;
    int         sedge = 0;

    always @(sck_o) begin
        int pos;
        int bi;
        bit lead;
        if (sl_on) begin
            pos  = sedge % 16;
            bi   = sedge / 16;
            lead = (sck_o != sl_cpol);
            if (!sl_cpha) begin
                if (lead) begin
                    cap = {cap[6:0], mosi_o};
                    if (pos == 14 && bi < 4) sl_in[bi] = cap;
                end else if (pos == 15) begin
                    if (bi + 1 < 4) miso_i = sl_out[bi+1][7];
                end else if (bi < 4) begin
                    miso_i = sl_out[bi][7-(pos+1)/2];
                end
            end else begin
                if (lead) begin
                    if (bi < 4) miso_i = sl_out[bi][7-pos/2];
                end else begin
                    cap = {cap[6:0], mosi_o};
                    if (pos == 15 && bi < 4) sl_in[bi] = cap;
                end
            end
            sedge++;
        end
    end

    task automatic run_vec(input vec_t v, input bit rel, input bit mid, input bit extra);
        int  t = 0, en = 0, tf = 0, tl = 0, td = 0, expi;
        int  gap_bad = 0, half_bad = 0, cs_bad = 0, oe_bad = 0;
        int  rx_n = 0, rx_bad = 0, txr_n = 0;
        bit  got_done = 0;
        logic sprev;
        cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_div = v.div; cfg_nbytes = v.n;
        cfg_lead_dly = v.lead; cfg_gap_dly = v.gap; cfg_tail_dly = v.tail;
        cfg_cs_idle = v.idle; cfg_cs_active = v.act; cfg_release = rel;
        cur_tx = v.tx; tx_idx = 0;
        for (int k = 0; k < 4; k++) begin
            sl_out[k] = bsel(v.sl, k);
            sl_in[k]  = 8'h00;
        end
        sl_cpol = v.cpol; sl_cpha = v.cpha; sedge = 0;
        miso_i  = v.cpha ? 1'b0 : sl_out[0][7];
        repeat (3) @(negedge clk);
        chk(cs_o == v.idle && sck_o == v.cpol, "R2 idle levels", {sck_o, cs_o}, {v.cpol, v.idle});
        chk(sck_oe == !rel && cs_oe == !rel && mosi_oe == !rel, "R12 idle enables",
            {sck_oe, cs_oe, mosi_oe}, {3{!rel}});
        sl_on = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sprev = v.cpol;
        while (!got_done && t < 4000) begin
            if (busy && cs_o != v.act) cs_bad++;
            if (busy && !(sck_oe && mosi_oe && cs_oe)) oe_bad++;
            if (sck_o !== sprev) begin
                en++;
                if (en == 1) begin
                    tf = t;
                end else begin
                    expi = ((en - 1) % 16 == 0) ? v.gap * UNIT + v.div + 2 : v.div + 1;
                    if (t - tl != expi) begin
                        if ((en - 1) % 16 == 0) gap_bad++;
                        else half_bad++;
                    end
                end
                tl = t;
                sprev = sck_o;
            end
            if (rx_valid) begin
                if (rx_n < 4 && rx_data !== bsel(v.sl, rx_n)) rx_bad++;
                rx_n++;
            end
            if (tx_ready) begin
                txr_n++;
                tx_idx++;
            end
            if (done) begin
                got_done = 1;
                td = t;
                sl_on = 1'b0;
                chk(cs_o == v.idle, "R7 idle pattern at done", cs_o, v.idle);
            end
            if (mid && t == 3) begin
                cfg_div = v.div + 8'd3; cfg_cs_active = ~v.act; cfg_nbytes = v.n + 8'd1;
                cfg_gap_dly = v.gap + 8'd2; cfg_tail_dly = v.tail + 8'd1;
                cfg_cpha = ~v.cpha; cfg_cs_idle = ~v.idle;
            end
            start = (extra && t == 6);
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        chk(got_done, "R7 done reached", got_done, 1);
        chk(cs_bad == 0, "R3 active pattern held", cs_bad, 0);
        chk(oe_bad == 0, "R12 enables while busy", oe_bad, 0);
        if (v.n != 0) begin
            chk(tf == v.lead * UNIT + v.div + 2, "R4 lead time", tf, v.lead * UNIT + v.div + 2);
            chk(en == 16 * v.n, "R5 transition count", en, 16 * v.n);
            chk(half_bad == 0, "R5 half period", half_bad, 0);
            chk(gap_bad == 0, "R6 byte gap", gap_bad, 0);
            chk(td - tl == v.tail * UNIT + 2, "R7 tail time", td - tl, v.tail * UNIT + 2);
        end else begin
            chk(en == 0, "R7 no clock for zero bytes", en, 0);
            chk(td == (v.lead + v.tail) * UNIT + 3, "R7 zero-byte length", td,
                (v.lead + v.tail) * UNIT + 3);
        end
        for (int k = 0; k < v.n && k < 4; k++) begin
            chk(sl_in[k] == bsel(v.tx, k), "R8 MOSI byte", sl_in[k], bsel(v.tx, k));
        end
        chk(rx_bad == 0, "R8 MISO byte", rx_bad, 0);
        chk(rx_n == v.n, "R9 rx_valid pulses", rx_n, v.n);
        chk(txr_n == v.n, "R10 tx_ready pulses", txr_n, v.n);
        if (mid) chk(cs_bad == 0 && en == 16 * v.n && half_bad == 0, "R11 settings held",
                     en, 16 * v.n);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        chk(sck_oe == !rel, "R12 enables after done", sck_oe, !rel);
        if (extra) begin
            repeat (4) @(negedge clk);
            chk(!busy, "R13 start ignored while busy", busy, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog: run did not finish actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t z;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_o == 4'hF, "R1 cs during reset", cs_o, 15);
        chk(!sck_o && !mosi_o, "R1 sck/mosi during reset", {sck_o, mosi_o}, 0);
        chk(!busy && !done && !rx_valid && !tx_ready, "R1 flags during reset",
            {busy, done, rx_valid, tx_ready}, 0);
        rst_n = 1'b1;
        // R2 idle tracking
        cfg_cs_idle = 4'h6; cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_o == 4'h6 && sck_o, "R2 idle follows settings", {sck_o, cs_o}, 22);
        cfg_cs_idle = 4'h9; cfg_cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs_o == 4'h9 && !sck_o, "R2 idle follows change", {sck_o, cs_o}, 9);
        // R12 release while idle
        cfg_release = 1'b1;
        @(negedge clk);
        chk(!sck_oe && !mosi_oe && !cs_oe, "R12 released", {sck_oe, mosi_oe, cs_oe}, 0);
        cfg_release = 1'b0;
        @(negedge clk);
        chk(sck_oe && mosi_oe && cs_oe, "R12 driven", {sck_oe, mosi_oe, cs_oe}, 7);
        // table of vectors
        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], i[0], 1'b0, 1'b0);
        end
        // zero-byte transfer (R7)
        z = VEC[0]; z.n = 8'd0; z.lead = 8'd2; z.tail = 8'd1;
        run_vec(z, 1'b1, 1'b0, 1'b0);
        // long lead delay (R4)
        z = VEC[4]; z.lead = 8'd10;
        run_vec(z, 1'b0, 1'b0, 1'b0);
        // settings changed mid-transfer (R11)
        run_vec(VEC[3], 1'b0, 1'b1, 1'b0);
        // start while busy (R13)
        run_vec(VEC[0], 1'b1, 1'b0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule